// File: doc/BRIEF.md
# Polynomial Noise Sampler and Mixer

The block makes the noise and tone content of a four-voice sound generator. Three free-running linear-feedback shift registers advance on every master clock and supply pseudo-random bits. The longest one can run at full length or at a shortened length. The shift registers are shared by all four voices. Each voice reads them only when its own divider pulse arrives, so each voice behaves as if it had private noise sources clocked at its own rate. This sampling also limits how fast the noise can change, which acts as a low-pass filter.

Each voice has an 8-bit control word. It selects the noise content or a plain square tone, sets a 4-bit volume, and can force a constant level. Voices 0 and 1 can each pass through a simple high-pass gate that is clocked by the pulse of voice 2 or voice 3. The block drives the four 4-bit levels and a registered 6-bit sum of them. The frequency dividers sit outside the block and deliver one-cycle pulses on `sample_i`.

Top module: `poly_noise_mixer`

## Requirements
- R1: Three shift registers step on every clock, each shifting left with the new bit entering at bit 0:
  - 4-bit: feedback bit3^bit2, output bit3.
  - 5-bit: feedback bit4^bit2, output bit4.
  - 17-bit: feedback bit16^bit13, output bit16.
  - All reset to all ones. When the active bits are all zero, the feedback is forced to 1.
- R2: When `poly_short_i`=1, the 17-bit register uses feedback bit8^bit4, outputs bit8, and checks bits 8..0 for the all-zero escape.
- R3: A voice's output flip-flop changes only on a clock edge where that voice's `sample_i` bit is 1.
- R4: On its pulse, the voice flip-flop toggles when permit = (ctl[7] | out5) & (ctl[5] | (ctl[6] ? out4 : out17)), where out17 is the output chosen by R2.
  - ctl[7]=1 bypasses the 5-bit gate.
  - ctl[5]=1 gives a pure square tone.
- R5: A voice's level on `level_o[4v+3:4v]` equals ctl[3:0] when its output bit is 1 and 0 otherwise. The level follows the flip-flops with no further register. Control word v is `ctl_i[8v+7:8v]`.
- R6: When ctl[4]=1, the level equals ctl[3:0] whatever the output bit is.
- R7: Voice p (p=0,1) has a high-pass flip-flop that captures voice p's output bit on the pulse of voice p+2.
  - While `hpf_en_i[p]`=1, the output bit of voice p is its flip-flop XOR the high-pass flip-flop.
- R8: `mix_o` is a register loaded each clock with the sum of the four levels, so it lags the levels by one cycle. Four levels of 15 give 60.
- R9: After reset, all voice and high-pass flip-flops are 0 and `mix_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_i | input | 32 | Four 8-bit voice control words, voice v at bits 8v+7..8v |
| sample_i | input | 4 | Divider pulse per voice, one cycle wide |
| poly_short_i | input | 1 | Shortens the 17-bit register to 9 bits |
| hpf_en_i | input | 2 | High-pass enable for voices 0 and 1 |
| level_o | output | 16 | Four 4-bit voice levels |
| mix_o | output | 6 | Registered sum of the levels |

## Verification
The bench keeps its own models of the shift registers and predicts each noise decision from them. It covers the 4-bit source, the full 17-bit source, the shortened 9-bit source and the 5-bit gate. A design with a wrong tap, a swapped source select or a missing gate diverges within a few dozen pulses. The high-pass sequence catches a high-pass flip-flop that is clocked by the wrong pulse or applied while disabled. The sum check at full volume catches an overflowed adder. A check taken just after a control change catches a sum that skips its register stage. Tone and idle checks catch a flip-flop that toggles without a pulse.

// File: rtl/noise_pkg.sv
`timescale 1ns/1ps
package noise_pkg;
  localparam int NUM_CH  = 4;
  localparam int NUM_HPF = NUM_CH / 2;
  localparam int CTL_W   = 8;
  localparam int VOL_W   = 4;
  localparam int MIX_W   = $clog2(NUM_CH * ((1 << VOL_W) - 1) + 1);

  // control word bit positions
  localparam int CB_GATE_OFF = 7;
  localparam int CB_SRC4     = 6;
  localparam int CB_TONE     = 5;
  localparam int CB_VOLONLY  = 4;

  typedef logic [VOL_W-1:0] vol_t;
  typedef logic [CTL_W-1:0] ctl_t;
endpackage

// File: rtl/noise_lfsr.sv
`timescale 1ns/1ps
module noise_lfsr #(
  parameter int WIDTH   = 17,
  parameter int TAP     = 13,
  parameter int SHORT_W = 9,
  parameter int SHORT_T = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic short_i,
  output logic bit_o
);
  logic [WIDTH-1:0] r_q;
  logic             fb;

  always_comb begin
    if (short_i) fb = (r_q[SHORT_W-1:0] == '0) ? 1'b1 : (r_q[SHORT_W-1] ^ r_q[SHORT_T]);
    else         fb = (r_q == '0) ? 1'b1 : (r_q[WIDTH-1] ^ r_q[TAP]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) r_q <= '1;
    else         r_q <= {r_q[WIDTH-2:0], fb};
  end

  assign bit_o = short_i ? r_q[SHORT_W-1] : r_q[WIDTH-1];

  p_nonzero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni) r_q != '0);
endmodule

// File: rtl/noise_channel.sv
`timescale 1ns/1ps
module noise_channel import noise_pkg::*; #(
  parameter bit HAS_HPF = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  ctl_t ctl_i,
  input  logic sample_i,
  input  logic partner_sample_i,
  input  logic hpf_en_i,
  input  logic p4_i,
  input  logic p5_i,
  input  logic pl_i,
  output vol_t level_o
);
  logic tone_q, permit, out_bit;

  assign permit = (ctl_i[CB_GATE_OFF] | p5_i) &
                  (ctl_i[CB_TONE] | (ctl_i[CB_SRC4] ? p4_i : pl_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tone_q <= 1'b0;
    else if (sample_i && permit) tone_q <= ~tone_q;
  end

  generate
    if (HAS_HPF) begin : g_hpf
      logic hpf_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               hpf_q <= 1'b0;
        else if (partner_sample_i) hpf_q <= tone_q;
      end
      assign out_bit = tone_q ^ (hpf_en_i & hpf_q);

      p_hpf_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !partner_sample_i |=> $stable(hpf_q));
    end else begin : g_plain
      logic unused_hpf;
      assign unused_hpf = hpf_en_i ^ partner_sample_i;
      assign out_bit    = tone_q;
    end
  endgenerate

  assign level_o = (ctl_i[CB_VOLONLY] | out_bit) ? ctl_i[VOL_W-1:0] : '0;

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(tone_q));
  p_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && permit) |=> (tone_q != $past(tone_q)));
endmodule

// File: rtl/noise_sum.sv
`timescale 1ns/1ps
module noise_sum #(
  parameter int N     = 4,
  parameter int W_IN  = 4,
  parameter int W_OUT = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N*W_IN-1:0] levels_i,
  output logic [W_OUT-1:0]  sum_o
);
  logic [W_OUT-1:0] sum_d;
  logic             armed_q;

  always_comb begin
    sum_d = '0;
    for (int i = 0; i < N; i++) sum_d = sum_d + W_OUT'(levels_i[i*W_IN +: W_IN]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o   <= '0;
      armed_q <= 1'b0;
    end else begin
      sum_o   <= sum_d;
      armed_q <= 1'b1;
    end
  end

  p_mix_lag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $stable(levels_i)) |=> $stable(sum_o));
endmodule

// File: rtl/poly_noise_mixer.sv
`timescale 1ns/1ps
module poly_noise_mixer import noise_pkg::*; (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH*CTL_W-1:0] ctl_i,
  input  logic [NUM_CH-1:0]       sample_i,
  input  logic                    poly_short_i,
  input  logic [NUM_HPF-1:0]      hpf_en_i,
  output logic [NUM_CH*VOL_W-1:0] level_o,
  output logic [MIX_W-1:0]        mix_o
);
  logic p4, p5, pl;

  noise_lfsr #(.WIDTH(4), .TAP(2), .SHORT_W(4), .SHORT_T(2)) i_lfsr4 (
    .clk_i, .rst_ni, .short_i(1'b0), .bit_o(p4));
  noise_lfsr #(.WIDTH(5), .TAP(2), .SHORT_W(5), .SHORT_T(2)) i_lfsr5 (
    .clk_i, .rst_ni, .short_i(1'b0), .bit_o(p5));
  noise_lfsr #(.WIDTH(17), .TAP(13), .SHORT_W(9), .SHORT_T(4)) i_lfsr17 (
    .clk_i, .rst_ni, .short_i(poly_short_i), .bit_o(pl));

  generate
    for (genvar v = 0; v < NUM_CH; v++) begin : g_ch
      noise_channel #(.HAS_HPF(v < NUM_HPF)) i_ch (
        .clk_i,
        .rst_ni,
        .ctl_i           (ctl_i[v*CTL_W +: CTL_W]),
        .sample_i        (sample_i[v]),
        .partner_sample_i(sample_i[(v + NUM_HPF) % NUM_CH]),
        .hpf_en_i        (hpf_en_i[v % NUM_HPF]),
        .p4_i            (p4),
        .p5_i            (p5),
        .pl_i            (pl),
        .level_o         (level_o[v*VOL_W +: VOL_W])
      );
    end
  endgenerate

  noise_sum #(.N(NUM_CH), .W_IN(VOL_W), .W_OUT(MIX_W)) i_sum (
    .clk_i, .rst_ni, .levels_i(level_o), .sum_o(mix_o));
endmodule

// File: tb/test_poly_noise_mixer.sv
`timescale 1ns/1ps
module test_poly_noise_mixer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctl = '0;
  logic [3:0]  smp = '0;
  logic        short_sel = 1'b0;
  logic [1:0]  hpf_en = '0;
  logic [15:0] level;
  logic [5:0]  mix;
  int checks = 0, errors = 0;

  logic [3:0]  m4;
  logic [4:0]  m5;
  logic [16:0] m17;

  always #4 clk = ~clk;

  poly_noise_mixer i_poly_noise_mixer (
    .clk_i(clk), .rst_ni(rst_n), .ctl_i(ctl), .sample_i(smp),
    .poly_short_i(short_sel), .hpf_en_i(hpf_en), .level_o(level), .mix_o(mix));

  // reference shift registers per R1/R2
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m4 <= '1; m5 <= '1; m17 <= '1;
    end else begin
      m4 <= {m4[2:0], (m4 == 0) ? 1'b1 : m4[3] ^ m4[2]};
      m5 <= {m5[3:0], (m5 == 0) ? 1'b1 : m5[4] ^ m5[2]};
      if (short_sel) m17 <= {m17[15:0], (m17[8:0] == 0) ? 1'b1 : m17[8] ^ m17[4]};
      else           m17 <= {m17[15:0], (m17 == 0) ? 1'b1 : m17[16] ^ m17[13]};
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lvl(input int ch);
    return int'(level[4*ch +: 4]);
  endfunction

  task automatic pulse(input int ch);
    @(negedge clk); smp[ch] = 1'b1;
    @(negedge clk); smp[ch] = 1'b0;
  endtask

  task automatic t_reset;
    chk(level == 0, "R9 level", level, 0);
    chk(mix == 0, "R9 mix", mix, 0);
    @(negedge clk);
    chk(mix == 0, "R9 mix after release", mix, 0);
  endtask

  task automatic t_tone;
    bit ff;
    int v = 9;
    @(negedge clk); ctl[31:24] = 8'hA9; #1;
    ff = lvl(3) != 0;
    for (int k = 0; k < 3; k++) begin
      pulse(3); ff = ~ff;
      chk(lvl(3) == (ff ? v : 0), "R4 tone toggle", lvl(3), ff ? v : 0);
    end
    repeat (5) @(negedge clk);
    chk(lvl(3) == (ff ? v : 0), "R3 hold without pulse", lvl(3), ff ? v : 0);
    ctl[31:24] = 8'h00;
  endtask

  task automatic t_volonly;
    @(negedge clk); ctl[15:8] = 8'h1A; #1;
    chk(lvl(1) == 10, "R6 volume only", lvl(1), 10);
    ctl[15:8] = 8'h1F; #1;
    chk(lvl(1) == 15, "R6 volume only max", lvl(1), 15);
    ctl[15:8] = 8'h00; #1;
    chk(lvl(1) == 0, "R5 zero volume", lvl(1), 0);
  endtask

  task automatic t_noise(input int ch, input logic [7:0] c, input bit sh, input string req);
    bit ff, permit, src;
    int bad = 0, v = int'(c[3:0]);
    int first_act = 0, first_exp = 0;
    @(negedge clk); ctl[8*ch +: 8] = c; short_sel = sh; #1;
    ff = lvl(ch) != 0;
    for (int k = 0; k < 60; k++) begin
      src = c[5] ? 1'b1 : (c[6] ? m4[3] : (sh ? m17[8] : m17[16]));
      permit = (c[7] | m5[4]) & src;
      smp[ch] = 1'b1;
      if (permit) ff = ~ff;
      @(negedge clk);
      if (lvl(ch) != (ff ? v : 0) && bad == 0) begin
        bad = 1; first_act = lvl(ch); first_exp = ff ? v : 0;
      end
    end
    smp[ch] = 1'b0;
    chk(bad == 0, req, first_act, first_exp);
    ctl[8*ch +: 8] = 8'h00; short_sel = 1'b0;
  endtask

  task automatic t_hpf(input int p);
    bit ff;
    int v = 7;
    @(negedge clk);
    ctl[8*p +: 8] = 8'hA7; ctl[8*(p+2) +: 8] = 8'h00; hpf_en[p] = 1'b0; #1;
    ff = lvl(p) != 0;
    pulse(p + 2);
    hpf_en[p] = 1'b1; #1;
    chk(lvl(p) == 0, "R7 hpf after capture", lvl(p), 0);
    pulse(p); ff = ~ff;
    chk(lvl(p) == v, "R7 hpf after own pulse", lvl(p), v);
    pulse(p + 2);
    chk(lvl(p) == 0, "R7 hpf recapture", lvl(p), 0);
    hpf_en[p] = 1'b0; #1;
    chk(lvl(p) == (ff ? v : 0), "R7 hpf disabled", lvl(p), ff ? v : 0);
    ctl[8*p +: 8] = 8'h00;
  endtask

  task automatic t_mix;
    @(negedge clk); ctl = {4{8'h1F}};
    @(negedge clk);
    chk(mix == 60, "R8 full scale sum", mix, 60);
    ctl[7:0] = 8'h13; #1;
    chk(mix == 60, "R8 one cycle lag", mix, 60);
    @(negedge clk);
    chk(mix == 48, "R8 updated sum", mix, 48);
    ctl = '0;
    @(negedge clk);
    chk(mix == 0, "R8 zero sum", mix, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_tone();
    t_volonly();
    t_noise(0, 8'hC6, 1'b0, "R4 four-bit source");
    t_noise(0, 8'h86, 1'b0, "R1 seventeen-bit source");
    t_noise(2, 8'h85, 1'b1, "R2 nine-bit source");
    t_noise(1, 8'h2B, 1'b0, "R4 five-bit gate");
    t_noise(3, 8'h0C, 1'b1, "R4 gate with short source");
    t_hpf(0);
    t_hpf(1);
    t_mix();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule